// File: doc/BRIEF.md
# Real-Mode Segmented Address Generator

This block produces the checked 32-bit linear address for one memory reference of a CPU that runs legacy 16-bit code. Each segment register has a cached descriptor: a 32-bit base, a 32-bit limit and a default-size attribute. A request names a segment and supplies addressing-mode operands. The block forms the effective offset, checks every byte of the operand against the cached limit, and adds the segment base. One cycle later it returns either an address strobe with the linear address or a fault flag with an interrupt vector.

While protection is off, writing a 16-bit value to a segment register sets that segment's base to the value times sixteen. The limit and the attribute stay as they are. Reset loads defaults under which ordinary 16-bit code cannot fault. Limit checking is never switched off, so an operand that runs past offset FFFFh still faults. Instruction decode, paging and protected-mode descriptor loading are handled elsewhere.

Top module: `rmag_top`

## Requirements
- R1: After reset every segment base is 0, every limit is 0000FFFFh, the code-segment default-size bit is 0, and addrValid and fault are low.
- R2: In 16-bit address size the offset is the sum of the low 16 bits of the selected base register (baseSel 0 = BX, 1 = BP, omitted when useBase is 0), the selected index register (indexSel 0 = SI, 1 = DI, omitted when useIndex is 0) and a displacement. The displacement is dispVal[7:0] sign-extended when dispWide is 0 and dispVal[15:0] when dispWide is 1. The sum is truncated to 16 bits and bits 31:16 of the offset are zero.
- R3: The address size is 32-bit when the code-segment default-size bit XOR addrOvr is 1. A 32-bit offset is the full 32-bit sum of the same terms, with the displacement being dispVal when dispWide is 1 and sign-extended dispVal[7:0] when dispWide is 0.
- R4: A reference faults when offset + bytes - 1 exceeds the segment limit, computed without overflow. opSize encodes the byte count as 0 = 1 byte, 1 = 2 bytes, 2 or 3 = 4 bytes.
- R5: A limit fault on the stack segment (segment code 2) reports vector 12. A fault on any other segment reports vector 13.
- R6: Segment codes are 0 = ES, 1 = CS, 2 = SS, 3 = DS, 4 = FS, 5 = GS. With protEn low, a write sets the named base to segWrVal shifted left by 4 bits. A write is ignored when protEn is high or when the code is 6 or 7.
- R7: The linear address is the segment base plus the offset modulo 2^32, with no wrap at 1 MB.
- R8: Outputs appear exactly one cycle after reqValid. A faulting reference raises fault and leaves addrValid low, and a cycle without a request leaves both low. A request with segment code 6 or 7 faults with vector 13.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| protEn | input | 1 | Protection enabled; blocks segment writes |
| segWrEn | input | 1 | Segment-register write strobe |
| segWrSel | input | 3 | Segment code being written |
| segWrVal | input | 16 | Selector value written |
| reqValid | input | 1 | Address request strobe |
| reqSeg | input | 3 | Segment code of the request |
| addrOvr | input | 1 | Address-size override for this request |
| opSize | input | 2 | Operand byte count code |
| useBase | input | 1 | Include base register term |
| baseSel | input | 1 | Base register select (0 BX, 1 BP) |
| useIndex | input | 1 | Include index register term |
| indexSel | input | 1 | Index register select (0 SI, 1 DI) |
| regBx | input | 32 | BX/EBX value |
| regBp | input | 32 | BP/EBP value |
| regSi | input | 32 | SI/ESI value |
| regDi | input | 32 | DI/EDI value |
| dispVal | input | 32 | Displacement |
| dispWide | input | 1 | Displacement is full width rather than 8-bit |
| linAddr | output | 32 | Linear address |
| addrValid | output | 1 | Address strobe, one cycle after request |
| fault | output | 1 | Limit fault, one cycle after request |
| faultVec | output | 8 | Fault vector number |

## Verification
The hardest cases to reach are offsets that land just below FFFFh and a multi-byte operand that crosses it. They are hard because a 16-bit sum that carries past 64K has to wrap back to a small offset rather than fault. The bench drives register values with nonzero upper halves and carry-producing low halves. It then sweeps every combination of base, index and displacement form, every operand size and every segment. Running the same sweep with the override bit set exposes the 32-bit path, where those same upper bits must now reach the limit check and fault.

// File: rtl/rmag_pkg.sv
package rmag_pkg;
  localparam int ADDR_W    = 32;
  localparam int SEL_W     = 16;
  localparam int SEG_IDX_W = 3;
  localparam int SEG_CNT   = 6;
  localparam int VEC_W     = 8;
  localparam int CODE_SEG  = 1;
  localparam int STACK_SEG = 2;
  localparam int DATA_SEG  = 3;
  localparam int SHIFT_W   = 4;
  localparam logic [ADDR_W-1:0] RESET_LIMIT = 32'h0000_FFFF;
  localparam logic [VEC_W-1:0]  VEC_STACK   = 8'd12;
  localparam logic [VEC_W-1:0]  VEC_GENERAL = 8'd13;

  typedef struct packed {
    logic                 segWr;
    logic [SEG_IDX_W-1:0] segWrIdx;
    logic                 req;
    logic [SEG_IDX_W-1:0] reqIdx;
    logic                 reqBad;
    logic                 isStack;
  } ctrlStrb_t;
endpackage

// File: rtl/rmag_ctrl.sv
module rmag_ctrl
  import rmag_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 protEn,
  input  logic                 segWrEn,
  input  logic [SEG_IDX_W-1:0] segWrSel,
  input  logic                 reqValid,
  input  logic [SEG_IDX_W-1:0] reqSeg,
  output ctrlStrb_t            strb
);
  logic wrInRange;
  logic reqInRange;

  always_comb begin
    wrInRange     = (int'(segWrSel) < SEG_CNT);
    reqInRange    = (int'(reqSeg) < SEG_CNT);
    strb.segWr    = segWrEn && !protEn && wrInRange;
    strb.segWrIdx = segWrSel;
    strb.req      = reqValid;
    strb.reqIdx   = reqInRange ? reqSeg : SEG_IDX_W'(DATA_SEG);
    strb.reqBad   = reqValid && !reqInRange;
    strb.isStack  = (int'(reqSeg) == STACK_SEG);
  end

  // R6: a write must never reach the cache while protection is on
  a_r6_prot_blocks_write: assert property (@(posedge clk) disable iff (!rstN)
    (segWrEn && protEn) |-> !strb.segWr);

  // R8: a folded request index always addresses a real cache entry
  a_r8_req_index_range: assert property (@(posedge clk) disable iff (!rstN)
    strb.req |-> (int'(strb.reqIdx) < SEG_CNT));
endmodule

// File: rtl/rmag_datapath.sv
module rmag_datapath
  import rmag_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrb_t          strb,
  input  logic [SEL_W-1:0]   segWrVal,
  input  logic               addrOvr,
  input  logic [1:0]         opSize,
  input  logic               useBase,
  input  logic               baseSel,
  input  logic               useIndex,
  input  logic               indexSel,
  input  logic [ADDR_W-1:0]  regBx,
  input  logic [ADDR_W-1:0]  regBp,
  input  logic [ADDR_W-1:0]  regSi,
  input  logic [ADDR_W-1:0]  regDi,
  input  logic [ADDR_W-1:0]  dispVal,
  input  logic               dispWide,
  output logic [ADDR_W-1:0]  linAddr,
  output logic               addrValid,
  output logic               fault,
  output logic [VEC_W-1:0]   faultVec
);
  localparam int PAD_W = ADDR_W - SEL_W - SHIFT_W;

  logic [ADDR_W-1:0] segBase  [SEG_CNT];
  logic [ADDR_W-1:0] segLimit [SEG_CNT];
  logic              segDflt  [SEG_CNT];

  genvar g;
  generate
    for (g = 0; g < SEG_CNT; g++) begin : g_cache
      always_ff @(posedge clk) begin
        if (!rstN) begin
          segBase[g]  <= '0;
          segLimit[g] <= RESET_LIMIT;
          segDflt[g]  <= 1'b0;
        end else if (strb.segWr && int'(strb.segWrIdx) == g) begin
          segBase[g] <= {{PAD_W{1'b0}}, segWrVal, {SHIFT_W{1'b0}}};
        end
      end

      // R6: base changes only on a write to this entry
      a_r6_base_hold: assert property (@(posedge clk) disable iff (!rstN)
        ($past(rstN) && !$past(strb.segWr && int'(strb.segWrIdx) == g))
          |-> $stable(segBase[g]));

      // R6: a write leaves selector times sixteen in the base
      a_r6_base_load: assert property (@(posedge clk) disable iff (!rstN)
        ($past(rstN) && $past(strb.segWr && int'(strb.segWrIdx) == g))
          |-> (segBase[g] == ($past({{PAD_W{1'b0}}, segWrVal}) << SHIFT_W)));
    end
  endgenerate

  logic              addr32;
  logic [ADDR_W-1:0] baseTerm, idxTerm, disp8x, dispTerm, offset, linNext;
  logic [SEL_W-1:0]  sum16;
  logic [ADDR_W:0]   lastByte;
  logic [1:0]        spanM1;
  logic              overLimit;

  always_comb begin
    addr32   = segDflt[CODE_SEG] ^ addrOvr;
    baseTerm = useBase  ? (baseSel  ? regBp : regBx) : '0;
    idxTerm  = useIndex ? (indexSel ? regDi : regSi) : '0;
    disp8x   = {{(ADDR_W-8){dispVal[7]}}, dispVal[7:0]};
    dispTerm = dispWide ? dispVal : disp8x;
    sum16    = baseTerm[SEL_W-1:0] + idxTerm[SEL_W-1:0] + dispTerm[SEL_W-1:0];
    if (addr32) offset = baseTerm + idxTerm + dispTerm;
    else        offset = {{(ADDR_W-SEL_W){1'b0}}, sum16};
    case (opSize)
      2'd0:    spanM1 = 2'd0;
      2'd1:    spanM1 = 2'd1;
      default: spanM1 = 2'd3;
    endcase
    lastByte  = {1'b0, offset} + {{(ADDR_W-1){1'b0}}, spanM1};
    overLimit = strb.reqBad || (lastByte > {1'b0, segLimit[strb.reqIdx]});
    linNext   = segBase[strb.reqIdx] + offset;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      linAddr   <= '0;
      addrValid <= 1'b0;
      fault     <= 1'b0;
      faultVec  <= '0;
    end else begin
      addrValid <= strb.req && !overLimit;
      fault     <= strb.req && overLimit;
      if (strb.req) begin
        linAddr  <= linNext;
        faultVec <= (strb.isStack && !strb.reqBad) ? VEC_STACK : VEC_GENERAL;
      end
    end
  end

  // R8: strobe and fault never together
  a_r8_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(addrValid && fault));

  // R8: any output event follows a request one cycle earlier
  a_r8_needs_request: assert property (@(posedge clk) disable iff (!rstN)
    (addrValid || fault) |-> $past(strb.req));

  // R5: a fault carries one of the two legal vectors
  a_r5_vector_legal: assert property (@(posedge clk) disable iff (!rstN)
    fault |-> (faultVec == VEC_STACK || faultVec == VEC_GENERAL));

  // R1: limits and default size keep their reset values
  a_r1_defaults_kept: assert property (@(posedge clk) disable iff (!rstN)
    (segLimit[CODE_SEG] == RESET_LIMIT) && !segDflt[CODE_SEG]);
endmodule

// File: rtl/rmag_top.sv
module rmag_top
  import rmag_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               protEn,
  input  logic               segWrEn,
  input  logic [2:0]         segWrSel,
  input  logic [15:0]        segWrVal,
  input  logic               reqValid,
  input  logic [2:0]         reqSeg,
  input  logic               addrOvr,
  input  logic [1:0]         opSize,
  input  logic               useBase,
  input  logic               baseSel,
  input  logic               useIndex,
  input  logic               indexSel,
  input  logic [31:0]        regBx,
  input  logic [31:0]        regBp,
  input  logic [31:0]        regSi,
  input  logic [31:0]        regDi,
  input  logic [31:0]        dispVal,
  input  logic               dispWide,
  output logic [31:0]        linAddr,
  output logic               addrValid,
  output logic               fault,
  output logic [7:0]         faultVec
);
  ctrlStrb_t strb;

  rmag_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .protEn(protEn), .segWrEn(segWrEn),
    .segWrSel(segWrSel), .reqValid(reqValid), .reqSeg(reqSeg), .strb(strb)
  );

  rmag_datapath u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .segWrVal(segWrVal),
    .addrOvr(addrOvr), .opSize(opSize), .useBase(useBase), .baseSel(baseSel),
    .useIndex(useIndex), .indexSel(indexSel), .regBx(regBx), .regBp(regBp),
    .regSi(regSi), .regDi(regDi), .dispVal(dispVal), .dispWide(dispWide),
    .linAddr(linAddr), .addrValid(addrValid), .fault(fault), .faultVec(faultVec)
  );
endmodule

// File: tb/test_rmag_top.sv
`timescale 1ns/1ps
module test_rmag_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic protEn = 1'b0, segWrEn = 1'b0, reqValid = 1'b0, addrOvr = 1'b0;
  logic [2:0] segWrSel = '0, reqSeg = '0;
  logic [15:0] segWrVal = '0;
  logic [1:0] opSize = '0;
  logic useBase = 1'b0, baseSel = 1'b0, useIndex = 1'b0, indexSel = 1'b0, dispWide = 1'b0;
  logic [31:0] regBx = '0, regBp = '0, regSi = '0, regDi = '0, dispVal = '0;
  logic [31:0] linAddr;
  logic addrValid, fault;
  logic [7:0] faultVec;

  int total = 0;
  int failed = 0;
  logic [15:0] expSel [6];

  always #2 clk = ~clk;

  rmag_top i_rmag_top (
    .clk(clk), .rstN(rstN), .protEn(protEn), .segWrEn(segWrEn), .segWrSel(segWrSel),
    .segWrVal(segWrVal), .reqValid(reqValid), .reqSeg(reqSeg), .addrOvr(addrOvr),
    .opSize(opSize), .useBase(useBase), .baseSel(baseSel), .useIndex(useIndex),
    .indexSel(indexSel), .regBx(regBx), .regBp(regBp), .regSi(regSi), .regDi(regDi),
    .dispVal(dispVal), .dispWide(dispWide), .linAddr(linAddr), .addrValid(addrValid),
    .fault(fault), .faultVec(faultVec)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic segWrite(input int seg, input logic [15:0] val);
    @(negedge clk);
    segWrEn = 1'b1; segWrSel = 3'(seg); segWrVal = val;
    @(negedge clk);
    segWrEn = 1'b0;
    if (!protEn && seg < 6) expSel[seg] = val;
  endtask

  task automatic request(input string tag, input int seg, input int ovr, input int size,
                         input int ub, input int bs, input int ui, input int is,
                         input int dw, input logic [31:0] d);
    logic [31:0] b, i, dd, off, lin;
    logic [32:0] last;
    logic expF;
    logic [7:0] expVec;
    b  = (ub != 0) ? ((bs != 0) ? regBp : regBx) : 32'h0;
    i  = (ui != 0) ? ((is != 0) ? regDi : regSi) : 32'h0;
    dd = (dw != 0) ? d : {{24{d[7]}}, d[7:0]};
    if (ovr == 0) begin
      if (dw != 0) dd = {16'h0, d[15:0]};
      off = (b + i + dd) & 32'h0000_FFFF;
    end else begin
      off = b + i + dd;
    end
    last = {1'b0, off} + 33'((size == 0) ? 0 : (size == 1) ? 1 : 3);
    expF = (seg > 5) || (last > 33'h0_0000_FFFF);
    expVec = (seg == 2) ? 8'd12 : 8'd13;
    lin = (seg < 6) ? ({12'h0, expSel[seg], 4'h0} + off) : 32'h0;
    @(negedge clk);
    reqValid = 1'b1; reqSeg = 3'(seg); addrOvr = ovr[0]; opSize = 2'(size);
    useBase = ub[0]; baseSel = bs[0]; useIndex = ui[0]; indexSel = is[0];
    dispWide = dw[0]; dispVal = d;
    @(negedge clk);
    reqValid = 1'b0;
    check({tag, " R8 fault"}, {31'h0, fault}, {31'h0, expF});
    check({tag, " R8 valid"}, {31'h0, addrValid}, {31'h0, !expF});
    if (expF) check({tag, " R5 vector"}, {24'h0, faultVec}, {24'h0, expVec});
    else      check({tag, " R7 linAddr"}, linAddr, lin);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    failed++; total++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

  initial begin : main
    for (int k = 0; k < 6; k++) expSel[k] = 16'h0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: outputs quiet after reset, bases zero, limit FFFF
    check("R1 valid after reset", {31'h0, addrValid}, 32'h0);
    check("R1 fault after reset", {31'h0, fault}, 32'h0);
    for (int s = 0; s < 6; s++) request("R1 base zero", s, 0, 0, 0, 0, 0, 0, 1, 32'h0);
    request("R1 R4 last byte", 3, 0, 0, 0, 0, 0, 0, 1, 32'h0000_FFFF);
    request("R1 R4 crossing word", 3, 0, 1, 0, 0, 0, 0, 1, 32'h0000_FFFF);
    request("R4 R5 stack crossing dword", 2, 0, 2, 0, 0, 0, 0, 1, 32'h0000_FFFD);
    request("R4 dword fits", 2, 0, 2, 0, 0, 0, 0, 1, 32'h0000_FFFC);

    // R8: idle cycle leaves outputs low
    @(negedge clk);
    check("R8 idle valid", {31'h0, addrValid}, 32'h0);
    check("R8 idle fault", {31'h0, fault}, 32'h0);

    // R6 R7: segment write sweep, no 1 MB wrap
    for (int s = 0; s < 6; s++) begin
      segWrite(s, 16'hFFFF);
      request("R6 R7 top base", s, 0, 0, 0, 0, 0, 0, 1, 32'h0000_FFFF);
      segWrite(s, 16'h1234 + 16'(s));
      request("R6 base", s, 0, 1, 0, 0, 0, 0, 1, 32'h0000_0010);
    end
    check("R7 no 1MB wrap", {12'h0, 16'hFFFF, 4'h0} + 32'hFFFF, 32'h0010_FFEF);

    // R6: ignored writes
    protEn = 1'b1;
    segWrite(3, 16'hABCD);
    protEn = 1'b0;
    request("R6 prot write ignored", 3, 0, 0, 0, 0, 0, 0, 1, 32'h0);
    segWrite(6, 16'h5555);
    segWrite(7, 16'h6666);
    for (int s = 0; s < 6; s++) request("R6 bad code ignored", s, 0, 0, 0, 0, 0, 0, 1, 32'h0);
    request("R8 bad seg 6", 6, 0, 0, 0, 0, 0, 0, 1, 32'h0);
    request("R8 bad seg 7", 7, 0, 0, 0, 0, 0, 0, 1, 32'h0);

    // R2 R3 R4 R5: operand sweep, 16-bit then overridden to 32-bit
    regBx = 32'h0001_F000; regBp = 32'h1234_8001;
    regSi = 32'hFFFF_0FFF; regDi = 32'h0000_7FFE;
    for (int ovr = 0; ovr < 2; ovr++)
      for (int ub = 0; ub < 2; ub++)
        for (int bs = 0; bs < 2; bs++)
          for (int ui = 0; ui < 2; ui++)
            for (int is = 0; is < 2; is++)
              for (int dw = 0; dw < 2; dw++)
                for (int dk = 0; dk < 3; dk++)
                  for (int sz = 0; sz < 4; sz++)
                    for (int s = 0; s < 6; s++) begin
                      logic [31:0] dv;
                      dv = (dk == 0) ? 32'h0000_0010 : (dk == 1) ? 32'hFFFF_FF7F : 32'h0000_FFFE;
                      request((ovr == 0) ? "R2 R4 ea16" : "R3 R4 ea32",
                              s, ovr, sz, ub, bs, ui, is, dw, dv);
                    end

    // R3: small 32-bit offset without high bits stays valid
    regBx = 32'h0000_0100;
    request("R3 ea32 small", 1, 1, 2, 1, 0, 0, 0, 0, 32'h0000_0004);

    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end
endmodule